// File: doc/BRIEF.md
# Port-Mapped Memory-Disk Controller

This block attaches a byte-wide storage array to the I/O space of an 8-bit processor bus. The host selects a byte by writing three address registers. Each register has its own output port and holds a track number, a sector number or a byte offset. Together the three registers form a 24-bit storage address. The host then moves data through one data port. An output to that port stores a byte at the selected address, and an input from it returns the byte held there. The address is never taken from the CPU address bus. The registers keep their values between accesses, so repeated data-port cycles reach the same byte until the host writes the registers again.

The block controls the timing of the storage write. The write strobe starts one clock after the data-port output is decoded and lasts one clock. The write data register then stays unchanged for one more clock, so the data on the storage side stays valid until after the strobe has ended. A read is answered from a registered copy of the storage output. That copy drives the CPU data bus only while a read window is open. The write-direction path is enabled at every other time. While a storage write is in progress, the block ignores every port access.

Top module: `mdisk_port_ctrl`

## Requirements
- R1: A synchronous active-high reset clears all three address registers to zero, deasserts the storage write strobe and the read driver enable, and leaves the write-direction path enabled.
- R2: Port 0x45 loads address bits [7:0], port 0x46 loads bits [15:8] and port 0x47 loads bits [23:16] from the output data byte. The new value appears on the storage address one clock after the bus cycle.
- R3: An output to port 0x44 raises the storage write strobe for exactly one clock, starting one clock after the decode. During that clock the storage write data equals the output byte, and the byte is stored at the latched address.
- R4: The storage write data stays unchanged during the strobe and for one clock after it. The write-direction path stays enabled over that whole span.
- R5: An input from port 0x44 returns the byte stored at the latched address. The read driver enable rises one clock after the read is decoded and falls one clock after the read request ends.
- R6: While the read driver enable is high, the write-direction path is disabled. At all other times the write-direction path is enabled.
- R7: A port is selected only when the I/O request qualifier is high and all 8 bits of the I/O address match. Cycles with the qualifier low and cycles to other port numbers change neither the address registers nor the storage.
- R8: While a storage write is in progress (the strobe clock and the hold clock after it), the block ignores data-port writes, data-port reads and address-register writes.
- R9: The address is not incremented automatically. Repeated data-port accesses without new register writes reach the same byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| io_req | input | 1 | I/O request qualifier; low marks a memory cycle |
| io_wr | input | 1 | Output (write) cycle strobe |
| io_rd | input | 1 | Input (read) cycle strobe |
| io_addr | input | 8 | Low byte of the I/O address |
| io_wdata | input | 8 | Data from the CPU |
| io_rdata | output | 8 | Registered read data toward the CPU |
| io_rdata_oe | output | 1 | Read driver enable (models the tri-state buffer) |
| mem_addr | output | 24 | Storage byte address {track, sector, offset} |
| mem_wdata | output | 8 | Storage write data |
| mem_wdata_oe | output | 1 | Write-direction path enable |
| mem_we | output | 1 | Storage write strobe |
| mem_rdata | input | 8 | Storage read data (registered by the storage) |

## Verification
A table of six address and data sets drives the main function. The sets differ in track, in sector, in offset and in data polarity (all zeros, all ones, alternating bits), so a register loaded into the wrong byte lane or a swapped data bit gives a wrong value. All six bytes are read back again after every write has finished, which separates a write to the right location from one that overwrote a neighbour. Directed cycles follow. They check the strobe and hold timing clock by clock. They send accesses to ports 0x43 and 0x48 and cycles with the qualifier low. They issue back-to-back accesses while a write is in progress, which shows that an access in the busy window is dropped rather than delayed.

// File: rtl/mdisk_pkg.sv
package mdisk_pkg;
    typedef enum logic [1:0] {
        PH_IDLE  = 2'd0,
        PH_PULSE = 2'd1,
        PH_HOLD  = 2'd2
    } wr_phase_e;
endpackage

// File: rtl/mdisk_decode.sv
module mdisk_decode #(
    parameter int                PORT_W    = 8,
    parameter int                NUM_AREG  = 3,
    parameter logic [PORT_W-1:0] BASE_PORT = 8'h44
) (
    input  logic                io_req,
    input  logic                io_wr,
    input  logic                io_rd,
    input  logic [PORT_W-1:0]   io_addr,
    input  logic                busy,
    output logic                data_wr,
    output logic                data_rd,
    output logic [NUM_AREG-1:0] areg_wr
);
    logic acc_ok;

    // Accesses are accepted only on qualified I/O cycles with no write in flight
    assign acc_ok  = io_req && !busy;
    assign data_wr = acc_ok && io_wr && (io_addr == BASE_PORT);
    assign data_rd = acc_ok && io_rd && (io_addr == BASE_PORT);

    for (genvar g = 0; g < NUM_AREG; g++) begin : g_areg_dec
        localparam logic [PORT_W-1:0] AREG_PORT = PORT_W'(BASE_PORT + 1 + g);
        assign areg_wr[g] = acc_ok && io_wr && (io_addr == AREG_PORT);
    end
endmodule

// File: rtl/mdisk_addr_latch.sv
module mdisk_addr_latch #(
    parameter int DATA_W   = 8,
    parameter int NUM_AREG = 3,
    localparam int ADDR_W  = DATA_W * NUM_AREG
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [NUM_AREG-1:0] areg_wr,
    input  logic [DATA_W-1:0]   wdata,
    output logic [ADDR_W-1:0]   addr
);
    typedef struct packed {
        logic [NUM_AREG-1:0][DATA_W-1:0] lane;
    } latch_t;

    latch_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        for (int k = 0; k < NUM_AREG; k++) begin
            if (areg_wr[k]) begin
                st_d.lane[k] = wdata;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign addr = st_q.lane;
endmodule

// File: rtl/mdisk_write_seq.sv
module mdisk_write_seq
    import mdisk_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [DATA_W-1:0] din,
    output logic              we,
    output logic              busy,
    output logic [DATA_W-1:0] wdata
);
    typedef struct packed {
        wr_phase_e         phase;
        logic [DATA_W-1:0] wdata;
    } seq_t;

    seq_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        case (st_q.phase)
            PH_IDLE: begin
                if (start) begin
                    st_d.phase = PH_PULSE;
                    st_d.wdata = din;
                end
            end
            PH_PULSE: st_d.phase = PH_HOLD;
            PH_HOLD:  st_d.phase = PH_IDLE;
            default:  st_d.phase = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '{phase: PH_IDLE, wdata: '0};
        end else begin
            st_q <= st_d;
        end
    end

    assign we    = (st_q.phase == PH_PULSE);
    assign busy  = (st_q.phase != PH_IDLE);
    assign wdata = st_q.wdata;
endmodule

// File: rtl/mdisk_rd_path.sv
module mdisk_rd_path #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              rd_hit,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic              oe,
    output logic [DATA_W-1:0] rdata
);
    typedef struct packed {
        logic              win;
        logic [DATA_W-1:0] data;
    } rd_t;

    rd_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        st_d.win = rd_hit;
        if (rd_hit) begin
            st_d.data = mem_rdata;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign oe    = st_q.win;
    assign rdata = st_q.data;
endmodule

// File: rtl/mdisk_port_ctrl.sv
module mdisk_port_ctrl #(
    parameter int                PORT_W    = 8,
    parameter int                DATA_W    = 8,
    parameter int                NUM_AREG  = 3,
    parameter logic [PORT_W-1:0] BASE_PORT = 8'h44,
    localparam int               ADDR_W    = DATA_W * NUM_AREG
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              io_req,
    input  logic              io_wr,
    input  logic              io_rd,
    input  logic [PORT_W-1:0] io_addr,
    input  logic [DATA_W-1:0] io_wdata,
    output logic [DATA_W-1:0] io_rdata,
    output logic              io_rdata_oe,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    output logic              mem_wdata_oe,
    output logic              mem_we,
    input  logic [DATA_W-1:0] mem_rdata
);
    logic                data_wr;
    logic                data_rd;
    logic [NUM_AREG-1:0] areg_wr;
    logic                seq_busy;
    logic                rd_oe;

    mdisk_decode #(
        .PORT_W    (PORT_W),
        .NUM_AREG  (NUM_AREG),
        .BASE_PORT (BASE_PORT)
    ) i_decode (
        .io_req  (io_req),
        .io_wr   (io_wr),
        .io_rd   (io_rd),
        .io_addr (io_addr),
        .busy    (seq_busy),
        .data_wr (data_wr),
        .data_rd (data_rd),
        .areg_wr (areg_wr)
    );

    mdisk_addr_latch #(
        .DATA_W   (DATA_W),
        .NUM_AREG (NUM_AREG)
    ) i_addr_latch (
        .clk     (clk),
        .rst     (rst),
        .areg_wr (areg_wr),
        .wdata   (io_wdata),
        .addr    (mem_addr)
    );

    mdisk_write_seq #(
        .DATA_W (DATA_W)
    ) i_write_seq (
        .clk   (clk),
        .rst   (rst),
        .start (data_wr),
        .din   (io_wdata),
        .we    (mem_we),
        .busy  (seq_busy),
        .wdata (mem_wdata)
    );

    mdisk_rd_path #(
        .DATA_W (DATA_W)
    ) i_rd_path (
        .clk       (clk),
        .rst       (rst),
        .rd_hit    (data_rd),
        .mem_rdata (mem_rdata),
        .oe        (rd_oe),
        .rdata     (io_rdata)
    );

    // The read driver and the write-direction path never drive at the same time
    assign io_rdata_oe  = rd_oe;
    assign mem_wdata_oe = !rd_oe;
endmodule

// File: rtl/mdisk_port_chk.sv
module mdisk_port_chk #(
    parameter int                PORT_W    = 8,
    parameter int                DATA_W    = 8,
    parameter int                ADDR_W    = 24,
    parameter logic [PORT_W-1:0] BASE_PORT = 8'h44
) (
    input logic              clk,
    input logic              rst,
    input logic              io_req,
    input logic              io_wr,
    input logic              io_rd,
    input logic [PORT_W-1:0] io_addr,
    input logic [DATA_W-1:0] io_wdata,
    input logic              io_rdata_oe,
    input logic [ADDR_W-1:0] mem_addr,
    input logic [DATA_W-1:0] mem_wdata,
    input logic              mem_wdata_oe,
    input logic              mem_we,
    input logic              busy
);
    localparam logic [PORT_W-1:0] LO_PORT = PORT_W'(BASE_PORT + 1);

    // R1
    reset_clear_chk: assert property (@(posedge clk)
        rst |=> (mem_addr == '0 && !mem_we && !io_rdata_oe && mem_wdata_oe));

    // R2
    lo_latch_chk: assert property (@(posedge clk) disable iff (rst)
        (io_req && io_wr && !busy && io_addr == LO_PORT)
        |=> (mem_addr[DATA_W-1:0] == $past(io_wdata)));

    // R3
    we_single_chk: assert property (@(posedge clk) disable iff (rst)
        mem_we |=> !mem_we);

    // R3
    we_after_decode_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(mem_we) |-> $past(io_req && io_wr && io_addr == BASE_PORT));

    // R4
    data_hold_chk: assert property (@(posedge clk) disable iff (rst)
        mem_we |=> ($stable(mem_wdata) && mem_wdata_oe));

    // R5
    oe_rise_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(io_rdata_oe) |-> $past(io_req && io_rd && io_addr == BASE_PORT));

    // R7
    no_req_chk: assert property (@(posedge clk) disable iff (rst)
        !io_req |=> $stable(mem_addr));

    // R8
    busy_addr_chk: assert property (@(posedge clk) disable iff (rst)
        mem_we |=> $stable(mem_addr));
endmodule

bind mdisk_port_ctrl mdisk_port_chk #(
    .PORT_W    (PORT_W),
    .DATA_W    (DATA_W),
    .ADDR_W    (ADDR_W),
    .BASE_PORT (BASE_PORT)
) i_port_chk (
    .clk          (clk),
    .rst          (rst),
    .io_req       (io_req),
    .io_wr        (io_wr),
    .io_rd        (io_rd),
    .io_addr      (io_addr),
    .io_wdata     (io_wdata),
    .io_rdata_oe  (io_rdata_oe),
    .mem_addr     (mem_addr),
    .mem_wdata    (mem_wdata),
    .mem_wdata_oe (mem_wdata_oe),
    .mem_we       (mem_we),
    .busy         (seq_busy)
);

// File: tb/test_mdisk_port_ctrl.sv
module test_mdisk_port_ctrl;
    localparam int MEM_DEPTH = 1024;
    localparam int MEM_AW    = $clog2(MEM_DEPTH);
    localparam int NVEC      = 6;
    // {track, sector, offset, data}
    localparam logic [31:0] VEC [NVEC] = '{
        32'h00_00_00_A5,
        32'h01_00_01_5A,
        32'h00_01_00_FF,
        32'h7E_02_80_00,
        32'hFF_03_FF_3C,
        32'h12_02_34_C3
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        io_req = 1'b0, io_wr = 1'b0, io_rd = 1'b0;
    logic [7:0]  io_addr = '0, io_wdata = '0;
    logic [7:0]  io_rdata;
    logic        io_rdata_oe;
    logic [23:0] mem_addr;
    logic [7:0]  mem_wdata;
    logic        mem_wdata_oe;
    logic        mem_we;
    logic [7:0]  mem_rdata = '0;
    logic [7:0]  mem [MEM_DEPTH];

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    mdisk_port_ctrl i_mdisk_port_ctrl (
        .clk          (clk),
        .rst          (rst),
        .io_req       (io_req),
        .io_wr        (io_wr),
        .io_rd        (io_rd),
        .io_addr      (io_addr),
        .io_wdata     (io_wdata),
        .io_rdata     (io_rdata),
        .io_rdata_oe  (io_rdata_oe),
        .mem_addr     (mem_addr),
        .mem_wdata    (mem_wdata),
        .mem_wdata_oe (mem_wdata_oe),
        .mem_we       (mem_we),
        .mem_rdata    (mem_rdata)
    );

    // Synchronous storage model, one clock of read latency
    always @(posedge clk) begin
        if (mem_we) mem[mem_addr[MEM_AW-1:0]] <= mem_wdata;
        mem_rdata <= mem[mem_addr[MEM_AW-1:0]];
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic io_out(input logic [7:0] port, input logic [7:0] data, input logic req = 1'b1);
        @(negedge clk);
        io_req = req; io_wr = 1'b1; io_addr = port; io_wdata = data;
        @(negedge clk);
        io_req = 1'b0; io_wr = 1'b0;
        repeat (2) @(negedge clk);
    endtask

    task automatic io_in(output logic [7:0] data, input string req);
        @(negedge clk);
        io_req = 1'b1; io_rd = 1'b1; io_addr = 8'h44;
        @(negedge clk);
        chk({req, " oe"}, 32'(io_rdata_oe), 32'd1);
        chk("R6 write path off in read", 32'(mem_wdata_oe), 32'd0);
        data = io_rdata;
        io_req = 1'b0; io_rd = 1'b0;
        @(negedge clk);
        chk("R5 oe falls", 32'(io_rdata_oe), 32'd0);
        chk("R6 write path back on", 32'(mem_wdata_oe), 32'd1);
    endtask

    task automatic set_addr(input logic [23:0] a);
        io_out(8'h45, a[7:0]);
        io_out(8'h46, a[15:8]);
        io_out(8'h47, a[23:16]);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [7:0]  rd;
        logic [23:0] a;
        repeat (3) @(negedge clk);
        // R1 reset state
        chk("R1 addr", 32'(mem_addr), 32'h0);
        chk("R1 we", 32'(mem_we), 32'h0);
        chk("R1 oe", 32'(io_rdata_oe), 32'h0);
        chk("R1 write path", 32'(mem_wdata_oe), 32'h1);
        rst = 1'b0;

        // Table walk: R2 address lanes, R3 write, R5 read
        for (int i = 0; i < NVEC; i++) begin
            set_addr(VEC[i][31:8]);
            chk("R2 address lanes", 32'(mem_addr), 32'(VEC[i][31:8]));
            io_out(8'h44, VEC[i][7:0]);
            io_in(rd, "R5");
            chk("R3/R5 readback", 32'(rd), 32'(VEC[i][7:0]));
        end
        // Second pass: no neighbour overwritten
        for (int i = 0; i < NVEC; i++) begin
            set_addr(VEC[i][31:8]);
            io_in(rd, "R5");
            chk("R3 second pass", 32'(rd), 32'(VEC[i][7:0]));
        end

        // R3/R4 strobe timing, R8 busy window
        a = 24'h00_01_10;
        set_addr(a);
        @(negedge clk);
        io_req = 1'b1; io_wr = 1'b1; io_addr = 8'h44; io_wdata = 8'h11;
        @(negedge clk);
        chk("R3 strobe on", 32'(mem_we), 32'd1);
        chk("R3 strobe data", 32'(mem_wdata), 32'h11);
        io_wdata = 8'h22;
        @(negedge clk);
        chk("R3 strobe one clock", 32'(mem_we), 32'd0);
        chk("R4 data held", 32'(mem_wdata), 32'h11);
        chk("R4 write path on", 32'(mem_wdata_oe), 32'd1);
        io_addr = 8'h45; io_wdata = 8'h99;
        @(negedge clk);
        io_req = 1'b0; io_wr = 1'b0;
        chk("R8 latch write ignored", 32'(mem_addr), 32'(a));
        chk("R8 no second strobe", 32'(mem_we), 32'd0);
        repeat (2) @(negedge clk);
        io_in(rd, "R8");
        chk("R8 busy write dropped", 32'(rd), 32'h11);

        // R9 repeated accesses hit the same byte
        io_in(rd, "R9");
        chk("R9 repeat read", 32'(rd), 32'h11);
        io_out(8'h44, 8'h77);
        chk("R9 address unchanged", 32'(mem_addr), 32'(a));
        io_in(rd, "R9");
        chk("R9 rewrite same byte", 32'(rd), 32'h77);

        // R7 other ports and unqualified cycles
        io_out(8'h43, 8'hEE);
        io_out(8'h48, 8'hEE);
        chk("R7 other ports", 32'(mem_addr), 32'(a));
        io_out(8'h45, 8'hEE, 1'b0);
        io_out(8'h44, 8'hEE, 1'b0);
        chk("R7 memory cycle", 32'(mem_addr), 32'(a));
        io_in(rd, "R7");
        chk("R7 storage untouched", 32'(rd), 32'h77);

        // R1 reset clears loaded registers
        set_addr(24'hABCDEF);
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        chk("R1 reset clears lanes", 32'(mem_addr), 32'h0);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule